// File: doc/BRIEF.md
# Two-World Security State Controller

This block keeps track of the security world of a processor core and filters its memory and peripheral traffic by that world. One world bit in a configuration register selects the world: 0 is the secure world and 1 is the normal world. A separate monitor mode handles every change of world. A monitor-call strobe enters monitor mode. Monitor code can then rewrite the world bit, and a return strobe leaves monitor mode for the world that the bit selects. Monitor mode runs with secure rights.

An address window defined by two bounds, `base` and `limit`, is reserved for the secure world. Each peripheral slot carries its own world assignment, and only accesses from that same world are accepted. Only the secure world can change the window bounds and the peripheral assignments. A write to any of the three configuration targets that the current mode does not allow is dropped and raises a one-cycle fault flag.

The memory request port uses valid/ready. After reset `mem_ready_o` stays high, so the block exerts no back-pressure. It drops low only while reset is held, and no request is taken then. Every accepted request gets a registered response one cycle later. The peripheral port is a plain strobe with the same one-cycle response. The responses carry no ready signal and cannot be stalled.

Top module: `world_guard`

## Requirements
- R1: After reset the core is in the secure world with the world bit cleared and monitor mode off. Every peripheral is assigned to the secure world. The window bounds hold their reset parameters. No response or fault flag is asserted, and `mem_ready_o` is 1.
- R2: A pulse on `smc_i` puts the block in monitor mode in the next cycle. While in monitor mode `world_ns_o` reads 0 (secure), whatever the stored world bit is.
- R3: In monitor mode, `ret_i` leaves monitor mode in the next cycle for the world held in the stored bit. Outside monitor mode `ret_i` has no effect. When `smc_i` and `ret_i` arrive together, `smc_i` wins.
- R4: A write of the world bit takes effect only in monitor mode. From any other mode the write is ignored and `cfg_fault_o` is 1 in the next cycle.
- R5: A memory request with `mem_valid_i` and `mem_ready_o` both high gets `mem_rsp_valid_o` exactly one cycle later, with grant or fault on `mem_rsp_fault_o`.
- R6: From the normal world, a read or write to an address A with base <= A <= limit faults. For such a write, `mem_wr_en_o` stays 0.
- R7: A normal-world access outside the window is granted. A secure-world or monitor-mode access to any address is granted. Each granted write pulses `mem_wr_en_o` together with its response.
- R8: The window bounds are written with `win_sel_i` 0 for base and 1 for limit. The write applies only in the secure world or in monitor mode. From the normal world it is ignored and `cfg_fault_o` is 1 in the next cycle.
- R9: A window whose limit is below its base protects no address.
- R10: A peripheral access is granted only when the slot's assignment (0 = secure, 1 = normal) equals the current world. It responds one cycle later on `per_rsp_valid_o`/`per_rsp_fault_o`. An index at or above the slot count always faults.
- R11: A peripheral assignment write applies only in the secure world or in monitor mode. From the normal world it is ignored and `cfg_fault_o` is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smc_i | input | 1 | Monitor-call strobe |
| ret_i | input | 1 | Return-from-monitor strobe |
| ns_wr_i | input | 1 | World-bit write strobe |
| ns_wdata_i | input | 1 | World-bit write value |
| win_wr_i | input | 1 | Window-bound write strobe |
| win_sel_i | input | 1 | 0 selects base, 1 selects limit |
| win_wdata_i | input | AW | Window-bound write value |
| pa_wr_i | input | 1 | Peripheral assignment write strobe |
| pa_idx_i | input | PW | Peripheral slot to assign |
| pa_ns_i | input | 1 | New assignment, 1 = normal world |
| mem_valid_i | input | 1 | Memory request valid |
| mem_ready_o | output | 1 | Memory request ready |
| mem_addr_i | input | AW | Memory request address |
| mem_write_i | input | 1 | 1 = write, 0 = read |
| mem_rsp_valid_o | output | 1 | Memory response valid |
| mem_rsp_fault_o | output | 1 | Memory response is a fault |
| mem_wr_en_o | output | 1 | Downstream write strobe for a granted write |
| per_valid_i | input | 1 | Peripheral access strobe |
| per_idx_i | input | PW | Peripheral slot accessed |
| per_rsp_valid_o | output | 1 | Peripheral response valid |
| per_rsp_fault_o | output | 1 | Peripheral response is a fault |
| world_ns_o | output | 1 | Current effective world, 1 = normal |
| monitor_o | output | 1 | Monitor mode active |
| cfg_fault_o | output | 1 | Refused configuration write |

## Verification
Four properties are asserted on every cycle:
- the one-cycle entry into monitor mode and the exit on return;
- the world bit and the window bounds holding steady outside the modes allowed to change them;
- the one-cycle response timing on both ports;
- the absence of a downstream write strobe alongside a fault.

Only the bench's scenarios can show the decisions themselves: which addresses fault in which world, how a dropped configuration write leaves earlier settings in force, how an inverted window opens every address, and how peripheral ownership flips after a secure reassignment.

// File: rtl/world_pkg.sv
package world_pkg;

  typedef enum logic {
    WIN_BASE  = 1'b0,
    WIN_LIMIT = 1'b1
  } win_reg_e;

  typedef struct packed {
    logic valid;
    logic fault;
  } resp_t;

  // Address inside an enabled window; an inverted window matches nothing.
  function automatic logic win_hit(input logic [31:0] addr,
                                   input logic [31:0] lo,
                                   input logic [31:0] hi);
    return (hi >= lo) && (addr >= lo) && (addr <= hi);
  endfunction

endpackage

// File: rtl/world_mode.sv
module world_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic smc_i,
  input  logic ret_i,
  input  logic ns_wr_i,
  input  logic ns_wdata_i,
  output logic mon_o,
  output logic ns_o,
  output logic sec_o,
  output logic fault_o
);

  logic mon_q, ns_q, flt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mon_q <= 1'b0;
      ns_q  <= 1'b0;
      flt_q <= 1'b0;
    end else begin
      flt_q <= ns_wr_i & ~mon_q;
      if (ns_wr_i && mon_q) ns_q <= ns_wdata_i;
      if (smc_i)             mon_q <= 1'b1;
      else if (ret_i && mon_q) mon_q <= 1'b0;
    end
  end

  assign mon_o   = mon_q;
  assign ns_o    = ns_q & ~mon_q;
  assign sec_o   = ~ns_o;
  assign fault_o = flt_q;

  assert_smc_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    smc_i |=> mon_q);
  assert_ret_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_q && ret_i && !smc_i) |=> !mon_q);
  assert_ns_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_q |=> $stable(ns_q));

endmodule

// File: rtl/world_mem_filter.sv
module world_mem_filter
  import world_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] BASE_RST  = '1,
  parameter logic [AW-1:0] LIMIT_RST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_i,
  input  logic          win_wr_i,
  input  logic          win_sel_i,
  input  logic [AW-1:0] win_wdata_i,
  input  logic          mem_valid_i,
  input  logic [AW-1:0] mem_addr_i,
  input  logic          mem_write_i,
  output logic          ready_o,
  output logic          rsp_valid_o,
  output logic          rsp_fault_o,
  output logic          wr_en_o,
  output logic          fault_o
);

  logic [AW-1:0] base_q, limit_q;
  logic          ready_q, flt_q, wr_q;
  resp_t         rsp_q;
  logic          accept, hit, deny;

  assign accept = mem_valid_i & ready_q;
  assign hit    = win_hit(32'(mem_addr_i), 32'(base_q), 32'(limit_q));
  assign deny   = hit & ~sec_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= BASE_RST;
      limit_q <= LIMIT_RST;
      ready_q <= 1'b0;
      flt_q   <= 1'b0;
      wr_q    <= 1'b0;
      rsp_q   <= '0;
    end else begin
      ready_q <= 1'b1;
      flt_q   <= win_wr_i & ~sec_i;
      if (win_wr_i && sec_i) begin
        if (win_reg_e'(win_sel_i) == WIN_BASE) base_q  <= win_wdata_i;
        else                                   limit_q <= win_wdata_i;
      end
      rsp_q.valid <= accept;
      rsp_q.fault <= accept & deny;
      wr_q        <= accept & mem_write_i & ~deny;
    end
  end

  assign ready_o     = ready_q;
  assign rsp_valid_o = rsp_q.valid;
  assign rsp_fault_o = rsp_q.fault;
  assign wr_en_o     = wr_q;
  assign fault_o     = flt_q;

  assert_rsp_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_i && ready_o) |=> rsp_valid_o);
  assert_no_wr_on_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault_o |-> !wr_en_o);
  assert_win_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_i |=> ($stable(base_q) && $stable(limit_q)));

endmodule

// File: rtl/world_per_filter.sv
module world_per_filter
  import world_pkg::*;
#(
  parameter int NPER = 6,
  parameter int PW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_i,
  input  logic          pa_wr_i,
  input  logic [PW-1:0] pa_idx_i,
  input  logic          pa_ns_i,
  input  logic          per_valid_i,
  input  logic [PW-1:0] per_idx_i,
  output logic          rsp_valid_o,
  output logic          rsp_fault_o,
  output logic          fault_o
);

  logic [NPER-1:0] own_q;
  logic            own_sel, in_range;
  logic            flt_q;
  resp_t           rsp_q;

  generate
    for (genvar g = 0; g < NPER; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n) own_q[g] <= 1'b0;
        else if (pa_wr_i && sec_i && (32'(pa_idx_i) == g)) own_q[g] <= pa_ns_i;
      end
    end
  endgenerate

  always_comb begin
    own_sel = 1'b0;
    for (int i = 0; i < NPER; i++)
      if (32'(per_idx_i) == i) own_sel = own_q[i];
  end

  assign in_range = 32'(per_idx_i) < NPER;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_q <= '0;
      flt_q <= 1'b0;
    end else begin
      flt_q       <= pa_wr_i & ~sec_i;
      rsp_q.valid <= per_valid_i;
      rsp_q.fault <= per_valid_i & (~in_range | (own_sel != ~sec_i));
    end
  end

  assign rsp_valid_o = rsp_q.valid;
  assign rsp_fault_o = rsp_q.fault;
  assign fault_o     = flt_q;

  assert_per_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    per_valid_i |=> rsp_valid_o);
  assert_per_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (per_valid_i && !in_range) |=> rsp_fault_o);
  assert_own_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_i |=> $stable(own_q));

endmodule

// File: rtl/world_guard.sv
module world_guard
  import world_pkg::*;
#(
  parameter int AW = 16,
  parameter int NPER = 6,
  parameter logic [AW-1:0] WIN_BASE_RST  = 16'hC000,
  parameter logic [AW-1:0] WIN_LIMIT_RST = 16'hFFFF,
  localparam int PW = (NPER > 1) ? $clog2(NPER) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smc_i,
  input  logic          ret_i,
  input  logic          ns_wr_i,
  input  logic          ns_wdata_i,
  input  logic          win_wr_i,
  input  logic          win_sel_i,
  input  logic [AW-1:0] win_wdata_i,
  input  logic          pa_wr_i,
  input  logic [PW-1:0] pa_idx_i,
  input  logic          pa_ns_i,
  input  logic          mem_valid_i,
  output logic          mem_ready_o,
  input  logic [AW-1:0] mem_addr_i,
  input  logic          mem_write_i,
  output logic          mem_rsp_valid_o,
  output logic          mem_rsp_fault_o,
  output logic          mem_wr_en_o,
  input  logic          per_valid_i,
  input  logic [PW-1:0] per_idx_i,
  output logic          per_rsp_valid_o,
  output logic          per_rsp_fault_o,
  output logic          world_ns_o,
  output logic          monitor_o,
  output logic          cfg_fault_o
);

  logic sec, mode_flt, win_flt, pa_flt;

  world_mode u_mode (
    .clk(clk), .rst_n(rst_n), .smc_i(smc_i), .ret_i(ret_i),
    .ns_wr_i(ns_wr_i), .ns_wdata_i(ns_wdata_i),
    .mon_o(monitor_o), .ns_o(world_ns_o), .sec_o(sec), .fault_o(mode_flt)
  );

  world_mem_filter #(.AW(AW), .BASE_RST(WIN_BASE_RST), .LIMIT_RST(WIN_LIMIT_RST)) u_mem (
    .clk(clk), .rst_n(rst_n), .sec_i(sec),
    .win_wr_i(win_wr_i), .win_sel_i(win_sel_i), .win_wdata_i(win_wdata_i),
    .mem_valid_i(mem_valid_i), .mem_addr_i(mem_addr_i), .mem_write_i(mem_write_i),
    .ready_o(mem_ready_o), .rsp_valid_o(mem_rsp_valid_o), .rsp_fault_o(mem_rsp_fault_o),
    .wr_en_o(mem_wr_en_o), .fault_o(win_flt)
  );

  world_per_filter #(.NPER(NPER), .PW(PW)) u_per (
    .clk(clk), .rst_n(rst_n), .sec_i(sec),
    .pa_wr_i(pa_wr_i), .pa_idx_i(pa_idx_i), .pa_ns_i(pa_ns_i),
    .per_valid_i(per_valid_i), .per_idx_i(per_idx_i),
    .rsp_valid_o(per_rsp_valid_o), .rsp_fault_o(per_rsp_fault_o), .fault_o(pa_flt)
  );

  assign cfg_fault_o = mode_flt | win_flt | pa_flt;

  assert_mon_secure_R2: assert property (@(posedge clk) disable iff (!rst_n)
    monitor_o |-> !world_ns_o);

endmodule

// File: tb/world_guard_bench.sv
module world_guard_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smc = 0, ret = 0, ns_wr = 0, ns_wd = 0, win_wr = 0, win_sel = 0;
  logic [15:0] win_wd = '0, mem_addr = '0;
  logic pa_wr = 0, pa_ns = 0, mem_valid = 0, mem_write = 0, per_valid = 0;
  logic [2:0] pa_idx = '0, per_idx = '0;
  logic mem_ready, mem_rv, mem_rf, mem_we, per_rv, per_rf, world_ns, mon, cfg_flt;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  world_guard u_world_guard (
    .clk(clk), .rst_n(rst_n), .smc_i(smc), .ret_i(ret), .ns_wr_i(ns_wr), .ns_wdata_i(ns_wd),
    .win_wr_i(win_wr), .win_sel_i(win_sel), .win_wdata_i(win_wd),
    .pa_wr_i(pa_wr), .pa_idx_i(pa_idx), .pa_ns_i(pa_ns),
    .mem_valid_i(mem_valid), .mem_ready_o(mem_ready), .mem_addr_i(mem_addr),
    .mem_write_i(mem_write), .mem_rsp_valid_o(mem_rv), .mem_rsp_fault_o(mem_rf),
    .mem_wr_en_o(mem_we), .per_valid_i(per_valid), .per_idx_i(per_idx),
    .per_rsp_valid_o(per_rv), .per_rsp_fault_o(per_rf),
    .world_ns_o(world_ns), .monitor_o(mon), .cfg_fault_o(cfg_flt)
  );

  // {world ns, write, addr[15:0], expected fault, expected write strobe}; default window C000..FFFF
  localparam logic [19:0] VEC [10] = '{
    {1'b0, 1'b0, 16'hC000, 1'b0, 1'b0},
    {1'b0, 1'b1, 16'hFFFF, 1'b0, 1'b1},
    {1'b1, 1'b0, 16'h1234, 1'b0, 1'b0},
    {1'b1, 1'b1, 16'h2000, 1'b0, 1'b1},
    {1'b1, 1'b0, 16'hC000, 1'b1, 1'b0},
    {1'b1, 1'b1, 16'hD000, 1'b1, 1'b0},
    {1'b1, 1'b1, 16'hBFFF, 1'b0, 1'b1},
    {1'b1, 1'b0, 16'hFFFF, 1'b1, 1'b0},
    {1'b0, 1'b1, 16'h0000, 1'b0, 1'b1},
    {1'b1, 1'b1, 16'hFFFF, 1'b1, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Monitor call, world-bit write, return: leaves the core in world ns
  task automatic set_world(input logic ns);
    smc = 1; step(); smc = 0;
    ns_wr = 1; ns_wd = ns; step(); ns_wr = 0;
    ret = 1; step(); ret = 0;
    step();
  endtask

  task automatic mem_req(input logic [15:0] a, input logic wr, input logic ef,
                         input logic ew, input string req);
    mem_valid = 1; mem_addr = a; mem_write = wr; step(); mem_valid = 0; mem_write = 0;
    check(mem_rv == 1'b1, "R5", mem_rv, 1);
    check(mem_rf == ef, req, mem_rf, ef);
    check(mem_we == ew, req, mem_we, ew);
    step();
    check(mem_rv == 1'b0, "R5", mem_rv, 0);
  endtask

  task automatic per_req(input logic [2:0] idx, input logic ef, input string req);
    per_valid = 1; per_idx = idx; step(); per_valid = 0;
    check(per_rv == 1'b1, "R10", per_rv, 1);
    check(per_rf == ef, req, per_rf, ef);
  endtask

  task automatic win_write(input logic sel, input logic [15:0] v);
    win_wr = 1; win_sel = sel; win_wd = v; step(); win_wr = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step(); rst_n = 1; step();
    // R1 reset state
    check(world_ns == 0 && mon == 0, "R1", {world_ns, mon}, 0);
    check(cfg_flt == 0 && mem_rv == 0 && per_rv == 0, "R1", {cfg_flt, mem_rv, per_rv}, 0);
    check(mem_ready == 1, "R1", mem_ready, 1);
    per_req(3'd2, 1'b0, "R1");

    // Table walk: R6, R7
    for (int i = 0; i < 10; i++) begin
      set_world(VEC[i][19]);
      check(world_ns == VEC[i][19], "R3", world_ns, VEC[i][19]);
      mem_req(VEC[i][17:2], VEC[i][18], VEC[i][1], VEC[i][0], VEC[i][1] ? "R6" : "R7");
    end

    // R2: monitor reads secure even with world bit set (now normal world)
    smc = 1; step(); smc = 0;
    check(mon == 1 && world_ns == 0, "R2", {mon, world_ns}, 2);
    mem_req(16'hC000, 1'b1, 1'b0, 1'b1, "R7");
    ret = 1; step(); ret = 0;
    check(mon == 0 && world_ns == 1, "R3", {mon, world_ns}, 1);

    // R4: world-bit write outside monitor ignored and flagged
    ns_wr = 1; ns_wd = 0; step(); ns_wr = 0;
    check(cfg_flt == 1, "R4", cfg_flt, 1);
    step();
    check(world_ns == 1 && cfg_flt == 0, "R4", {world_ns, cfg_flt}, 2);

    // R3: return outside monitor ignored; smc wins over return
    ret = 1; step(); ret = 0;
    check(mon == 0 && world_ns == 1, "R3", {mon, world_ns}, 1);
    smc = 1; ret = 1; step(); smc = 0; ret = 0;
    check(mon == 1, "R3", mon, 1);
    ret = 1; step(); ret = 0;
    check(mon == 0 && world_ns == 1, "R3", {mon, world_ns}, 1);

    // R8: normal-world bound write refused, window unchanged
    win_write(1'b0, 16'h0000);
    check(cfg_flt == 1, "R8", cfg_flt, 1);
    mem_req(16'h1000, 1'b1, 1'b0, 1'b1, "R8");
    mem_req(16'hC000, 1'b0, 1'b1, 1'b0, "R8");

    // R8: secure moves window to 1000..1FFF
    set_world(1'b0);
    win_write(1'b0, 16'h1000);
    win_write(1'b1, 16'h1FFF);
    check(cfg_flt == 0, "R8", cfg_flt, 0);
    set_world(1'b1);
    mem_req(16'h1800, 1'b1, 1'b1, 1'b0, "R8");
    mem_req(16'h1FFF, 1'b0, 1'b1, 1'b0, "R8");
    mem_req(16'hC000, 1'b1, 1'b0, 1'b1, "R8");

    // R9: inverted window opens every address
    set_world(1'b0);
    win_write(1'b0, 16'h3000);
    win_write(1'b1, 16'h2000);
    set_world(1'b1);
    mem_req(16'h2800, 1'b1, 1'b0, 1'b1, "R9");
    mem_req(16'h3000, 1'b0, 1'b0, 1'b0, "R9");
    mem_req(16'h1800, 1'b1, 1'b0, 1'b1, "R9");

    // R10/R11: peripheral ownership
    per_req(3'd2, 1'b1, "R10");
    pa_wr = 1; pa_idx = 3'd2; pa_ns = 1; step(); pa_wr = 0;
    check(cfg_flt == 1, "R11", cfg_flt, 1);
    step();
    per_req(3'd2, 1'b1, "R11");
    set_world(1'b0);
    pa_wr = 1; pa_idx = 3'd2; pa_ns = 1; step(); pa_wr = 0;
    check(cfg_flt == 0, "R11", cfg_flt, 0);
    per_req(3'd2, 1'b1, "R10");
    per_req(3'd3, 1'b0, "R10");
    per_req(3'd7, 1'b1, "R10");
    set_world(1'b1);
    per_req(3'd2, 1'b0, "R10");
    per_req(3'd6, 1'b1, "R10");

    // R1: reset again restores secure world and window defaults
    rst_n = 0; step(); rst_n = 1; step();
    check(world_ns == 0 && mon == 0, "R1", {world_ns, mon}, 0);
    set_world(1'b1);
    mem_req(16'hC000, 1'b0, 1'b1, 1'b0, "R1");
    per_req(3'd2, 1'b1, "R1");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule